// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Decay Control

This block turns a handful of control levels into the four gate commands of one full bridge: a high-side and a low-side switch on each of two legs, A and B. The phase input chooses the current direction through the winding. The chop input, raised by an external current regulator, starts an off interval. During that interval the decay-select input picks one of two recirculation styles. In fast decay the bridge opens, and after a guard interval only the low-side switch across the conducting diode is closed again. This rectifies on one side only, so the current cannot reverse once it reaches zero. In slow decay only the conducting low-side switch opens, the current circulates through the two upper switches, and after the guard interval the other upper switch closes to rectify.

Every switch that turns on waits until its partner on the same leg has been off for `DEAD_CYC` clock cycles. Every switch that turns off does so on the next clock edge. A phase change while driving therefore acts as a leg transition. The global enable and the bridge enable each force all four gates off.

Top module: `hbridge_gate_seq`

## Requirements
- R1: The high and low gates of the same leg are never on together.
- R2: A gate whose target turns off drops on the next clock edge. A gate that turns on rises only once its same-leg partner has been off for `DEAD_CYC` cycles. If the partner falls at edge e, the gate rises at edge e+DEAD_CYC. If the partner has been off for that long already, the gate rises at the next edge.
- R3: With chop low and both enables high, phase=1 selects the pattern leg-A high and leg-B low, and phase=0 selects leg-B high and leg-A low. A change of phase first drops the outgoing pair, then raises the incoming pair under R2.
- R4: With chop high and decay_slow=0, only the low gate of the leg that was high is on: leg-A low for phase=1, leg-B low for phase=0. Both high gates stay off.
- R5: With chop high and decay_slow=1, both high gates are on and both low gates are off. The upper switch that was already on stays on, and the other one rises under R2.
- R6: glb_en=0 turns all four gates off on the next edge, whatever the other inputs are.
- R7: br_en=0 keeps all four gates off.
- R8: Synchronous reset (rst_n=0) clears all gates. After release, the first gate rises DEAD_CYC edges after the first active edge counts begin, that is at the DEAD_CYC-th edge with rst_n high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| glb_en | input | 1 | Global enable, 0 forces all gates off |
| br_en | input | 1 | Bridge enable from the step sequencer |
| phase | input | 1 | Current direction: 1 drives A to B, 0 drives B to A |
| chop | input | 1 | Off-interval request from the current regulator |
| decay_slow | input | 1 | 1 selects slow decay, 0 selects fast decay |
| gate_a_hi | output | 1 | Leg A high-side gate |
| gate_a_lo | output | 1 | Leg A low-side gate |
| gate_b_hi | output | 1 | Leg B high-side gate |
| gate_b_lo | output | 1 | Leg B low-side gate |

## Verification
The bench builds the block with DEAD_CYC=3. At that value a guard interval lasts a few cycles, so every ordered pair of the 32 input combinations can be run as a transition from a settled state. That covers 1024 transitions, including drive to decay, decay back to drive, phase reversal, and enable drops from every state. The output is compared on each edge across the whole guard interval, so both the instant of each rising gate and the immediate drop of each falling gate are checked. A separate run releases reset with drive already requested, to check the first turn-on delay.

// File: rtl/hb_pkg.sv
// Shared types for the H-bridge gate sequencer.
// Assumes two legs per bridge; leg index 0 is leg A, index 1 is leg B.
package hb_pkg;
    localparam int NUM_LEGS = 2;

    typedef struct packed {
        logic hi;
        logic lo;
    } leg_gate_t;
endpackage

// File: rtl/hb_target.sv
// Combinational target pattern for the four gates.
// Computes which switches should conduct in the present mode, ignoring
// deadtime; the per-leg sequencers apply timing. Targets never request
// both switches of one leg.
module hb_target
    import hb_pkg::*;
(
    input  logic                      glb_en,
    input  logic                      br_en,
    input  logic                      phase,
    input  logic                      chop,
    input  logic                      decay_slow,
    output leg_gate_t [NUM_LEGS-1:0]  want
);
    // Select drive, fast-decay, slow-decay or off pattern.
    always_comb begin
        want = '0;
        if (glb_en && br_en) begin
            if (!chop) begin
                want[0].hi = phase;
                want[1].lo = phase;
                want[1].hi = !phase;
                want[0].lo = !phase;
            end else if (!decay_slow) begin
                want[0].lo = phase;
                want[1].lo = !phase;
            end else begin
                want[0].hi = 1'b1;
                want[1].hi = 1'b1;
            end
        end
    end
endmodule

// File: rtl/hb_leg.sv
// One bridge leg with deadtime insertion.
// A gate drops on the edge after its target clears; it rises only after
// its partner has been off for DEAD_CYC cycles. Requires DEAD_CYC >= 1.
module hb_leg
    import hb_pkg::*;
#(
    parameter int DEAD_CYC = 125
) (
    input  logic      clk,
    input  logic      rst_n,
    input  leg_gate_t want,
    output leg_gate_t gate
);
    localparam int CW = $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] READY = CW'(DEAD_CYC - 1);

    logic          hi_q, lo_q;
    logic [CW-1:0] hi_off_cnt, lo_off_cnt;
    logic          hi_nxt, lo_nxt;

    // Next gate state: hold while wanted, rise only when partner is settled off.
    always_comb begin
        hi_nxt = want.hi && !want.lo && (hi_q || (!lo_q && lo_off_cnt == READY));
        lo_nxt = want.lo && !want.hi && (lo_q || (!hi_q && hi_off_cnt == READY));
    end

    // Gate registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= 1'b0;
            lo_q <= 1'b0;
        end else begin
            hi_q <= hi_nxt;
            lo_q <= lo_nxt;
        end
    end

    // Saturating off-time counters, one per switch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_off_cnt <= '0;
            lo_off_cnt <= '0;
        end else begin
            if (hi_q)                     hi_off_cnt <= '0;
            else if (hi_off_cnt != READY) hi_off_cnt <= hi_off_cnt + 1'b1;
            if (lo_q)                     lo_off_cnt <= '0;
            else if (lo_off_cnt != READY) lo_off_cnt <= lo_off_cnt + 1'b1;
        end
    end

    assign gate.hi = hi_q;
    assign gate.lo = lo_q;

    // R1: leg never shorts.
    a_r1_leg_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_q && lo_q));
    // R2: a rising gate always had its partner off the cycle before.
    a_r2_hi_rise_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_q) |-> $past(!lo_q));
    a_r2_lo_rise_guarded: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_q) |-> $past(!hi_q));
    // R2: a cleared target drops the gate on the next edge.
    a_r2_hi_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !want.hi |=> !hi_q);
    a_r2_lo_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !want.lo |=> !lo_q);
endmodule

// File: rtl/hbridge_gate_seq.sv
// H-bridge gate sequencer: mode decode plus two deadtime-guarded legs.
// Assumes all inputs are synchronous to clk. DEAD_CYC is the guard
// interval in clock cycles and must be at least 1.
module hbridge_gate_seq
    import hb_pkg::*;
#(
    parameter int DEAD_CYC = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic glb_en,
    input  logic br_en,
    input  logic phase,
    input  logic chop,
    input  logic decay_slow,
    output logic gate_a_hi,
    output logic gate_a_lo,
    output logic gate_b_hi,
    output logic gate_b_lo
);
    leg_gate_t [NUM_LEGS-1:0] want;
    leg_gate_t [NUM_LEGS-1:0] gate;

    hb_target u_target (
        .glb_en     (glb_en),
        .br_en      (br_en),
        .phase      (phase),
        .chop       (chop),
        .decay_slow (decay_slow),
        .want       (want)
    );

    // One deadtime sequencer per leg.
    for (genvar i = 0; i < NUM_LEGS; i++) begin : g_leg
        hb_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
            .clk   (clk),
            .rst_n (rst_n),
            .want  (want[i]),
            .gate  (gate[i])
        );
    end

    assign gate_a_hi = gate[0].hi;
    assign gate_a_lo = gate[0].lo;
    assign gate_b_hi = gate[1].hi;
    assign gate_b_lo = gate[1].lo;

    // R6: global disable clears every gate one edge later.
    a_r6_global_off: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!glb_en) |-> !(gate_a_hi || gate_a_lo || gate_b_hi || gate_b_lo));
    // R7: bridge disable keeps every gate off.
    a_r7_bridge_off: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!br_en) |-> !(gate_a_hi || gate_a_lo || gate_b_hi || gate_b_lo));
    // R4: fast decay never closes a high side.
    a_r4_fast_no_high: assert property (@(posedge clk) disable iff (!rst_n)
        $past(chop && !decay_slow) |-> !gate_a_hi && !gate_b_hi);
    // R5: slow decay never closes a low side.
    a_r5_slow_no_low: assert property (@(posedge clk) disable iff (!rst_n)
        $past(chop && decay_slow) |-> !gate_a_lo && !gate_b_lo);
    // R3: drive never closes both switches on the same rail.
    a_r3_drive_diagonal: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!chop) |-> !(gate_a_hi && gate_b_hi) && !(gate_a_lo && gate_b_lo));
endmodule

// File: tb/tb_hbridge_gate_seq.sv
// Sweep bench: every ordered pair of the 32 input vectors, checked edge by edge.
module tb_hbridge_gate_seq;
    localparam int D = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic glb_en = 1'b0, br_en = 1'b0, phase = 1'b0, chop = 1'b0, decay_slow = 1'b0;
    logic gate_a_hi, gate_a_lo, gate_b_hi, gate_b_lo;
    int checks = 0;
    int errors = 0;

    always #4 clk = !clk;

    hbridge_gate_seq #(.DEAD_CYC(D)) dut (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .br_en(br_en), .phase(phase),
        .chop(chop), .decay_slow(decay_slow), .gate_a_hi(gate_a_hi),
        .gate_a_lo(gate_a_lo), .gate_b_hi(gate_b_hi), .gate_b_lo(gate_b_lo)
    );

    // Pattern bits: {a_hi, a_lo, b_hi, b_lo}; vector bits {glb, br, phase, chop, slow}.
    function automatic logic [3:0] target_of(input logic [4:0] v);
        if (!v[4] || !v[3]) return 4'b0000;
        if (!v[1])          return v[2] ? 4'b1001 : 4'b0110;
        if (!v[0])          return v[2] ? 4'b0100 : 4'b0001;
        return 4'b1010;
    endfunction

    function automatic logic [3:0] expect_at(input logic [3:0] oldp, input logic [3:0] newp,
                                              input int k);
        logic [3:0] e;
        for (int g = 0; g < 4; g++) begin
            if (!newp[g])          e[g] = 1'b0;
            else if (oldp[g])      e[g] = 1'b1;
            else if (oldp[g ^ 1])  e[g] = (k >= D);
            else                   e[g] = 1'b1;
        end
        return e;
    endfunction

    function automatic string tag_of(input logic [4:0] v);
        if (!v[4]) return "R6";
        if (!v[3]) return "R7";
        if (!v[1]) return "R3";
        if (!v[0]) return "R4";
        return "R5";
    endfunction

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: gates actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic apply(input logic [4:0] v);
        {glb_en, br_en, phase, chop, decay_slow} = v;
    endtask

    function automatic logic [3:0] gates();
        return {gate_a_hi, gate_a_lo, gate_b_hi, gate_b_lo};
    endfunction

    initial begin
        #(100000 * 8);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R8: reset with drive requested.
        apply(5'b11100);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8", gates(), 4'b0000);
        rst_n = 1'b1;
        for (int k = 1; k <= D + 1; k++) begin
            @(posedge clk); @(negedge clk);
            check("R8", gates(), (k >= D) ? 4'b1001 : 4'b0000);
        end

        // Near-exhaustive transition sweep (R2..R7), R1 on every sample.
        for (int f = 0; f < 32; f++) begin
            for (int t = 0; t < 32; t++) begin
                logic [3:0] oldp, newp, exp;
                apply(5'(f));
                repeat (D + 2) @(posedge clk);
                @(negedge clk);
                oldp = target_of(5'(f));
                newp = target_of(5'(t));
                apply(5'(t));
                for (int k = 0; k <= D; k++) begin
                    @(posedge clk); @(negedge clk);
                    exp = expect_at(oldp, newp, k);
                    if (exp != newp) check("R2", gates(), exp);
                    else             check(tag_of(5'(t)), gates(), exp);
                    check("R1", {1'b0, gate_a_hi && gate_a_lo, 1'b0, gate_b_hi && gate_b_lo},
                          4'b0000);
                end
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule